// File: doc/BRIEF.md
# Three-Frame Serial Display Register Port

This block is a serial master that reaches the register file of a display driver chip over a three-wire link. The link has an active-low chip select, a serial clock, a data-out line with an enable that lets the pad release it, and a data-in line. A user on the system side presents one request at a time. A write request carries a 16-bit register address and an 8-bit parameter. A read request carries only the address.

Every request is split into three separate chip-select frames of 16 serial bits each. Each frame begins with a three-bit header: a read/not-write flag, a data/command flag and a byte-select flag. Five zero pad bits follow, and then a data byte sent most significant bit first. The first two frames send the upper address byte and then the lower one. The third frame either sends the parameter or turns the line round and collects one byte from the slave.

A parameter sets the length of each half of the serial clock in system clocks. A second parameter sets the minimum idle time of chip select between frames. A busy flag covers the whole access. A read result is given back with a one-cycle strobe.

Top module: `lcd_reg_port`

## Requirements
- R1: After reset and whenever idle, lcd_cs_n is 1, lcd_sclk is 0, lcd_sdo is 0, busy is 0 and rd_valid is 0.
- R2: Each chip-select low period contains exactly 16 rising edges of lcd_sclk. The bit sent on edge k (k = 1..16) is bit 16-k of the frame word. The word is laid out as {rnw[15], dcx[14], hsel[13], five zero bits [12:8], byte[7:0]}. The serial clock rises only while chip select is low.
- R3: A write request (req_read=0) produces exactly three frames, in this order: 16'h2000 | addr[15:8], then 16'h0000 | addr[7:0], then 16'h4000 | wdata.
- R4: A read request (req_read=1) produces the same first two frames, then a third frame whose header is rnw=1, dcx=1, hsel=0 with zero pad bits. During that frame's 8 data bits lcd_sdo_en is 0 and lcd_sdo is 0, so the observed third word is 16'hC000.
- R5: On a read, lcd_sdi is sampled once in each of the 8 data-bit high phases of lcd_sclk, at the last system clock before the falling edge. The bits are assembled most significant bit first. rd_data is presented with rd_valid high for exactly one cycle, in the same cycle that the third frame's chip select rises. A write produces no rd_valid.
- R6: lcd_sclk idles low. Within a frame, each high phase and each low phase lasts exactly HALF_CLKS system clocks. lcd_sdo does not change while lcd_sclk is high.
- R7: Between consecutive frames of one access, lcd_cs_n stays high for at least GAP_CLKS system clocks.
- R8: busy rises in the cycle after a request is accepted (req_valid=1 while busy=0). It stays high through the first two frame ends. It falls in the same cycle that the third frame's chip select rises.
- R9: A request presented while busy is high is ignored: the access in progress keeps its address, data and kind, and no extra frames follow it.
- R10: lcd_sdo_en is 1 at all times except during the 8 data bits of a read's third frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 16 | Register address |
| req_wdata | input | 8 | Parameter byte for a write |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| rd_data | output | 8 | Byte captured by a read |
| lcd_cs_n | output | 1 | Active-low chip select |
| lcd_sclk | output | 1 | Serial clock, idles low |
| lcd_sdo | output | 1 | Serial data to the slave |
| lcd_sdo_en | output | 1 | Data-out drive enable, low while the slave talks |
| lcd_sdi | input | 1 | Serial data from the slave |

## Verification
The hardest case to reach from the ports is the read turnaround. For the byte to be assembled correctly, the slave must present its bits only after the master has released the line, and each bit must still hold at the instant the master samples it, late in the high phase. The bench models a slave that follows the serial clock. After the eighth rising edge of the third frame, it changes lcd_sdi on each falling edge. It also records the drive enable at every rising edge, so the release window and the captured byte are both checked against the bit count. A second request is also injected in the middle of a write, to show that it leaves both the frames and the strobe untouched.

// File: rtl/lcdser_pkg.sv
package lcdser_pkg;

  localparam int HDR_W      = 3;
  localparam int PAD_W      = 5;
  localparam int BYTE_W     = 8;
  localparam int FRAME_W    = HDR_W + PAD_W + BYTE_W;
  localparam int ADDR_W     = 2 * BYTE_W;
  localparam int DATA_START = HDR_W + PAD_W;
  localparam int NUM_FRAMES = 3;

  typedef struct packed {
    logic rnw;   // 1 = slave drives the data byte
    logic dcx;   // 1 = parameter, 0 = address byte
    logic hsel;  // 1 = upper address byte
  } hdr_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FRAME = 2'd1,
    SQ_GAP   = 2'd2
  } seq_state_t;

  function automatic logic [FRAME_W-1:0] build_frame(input hdr_t h, input logic [BYTE_W-1:0] b);
    return {h, {PAD_W{1'b0}}, b};
  endfunction

endpackage

// File: rtl/lcdser_tick.sv
module lcdser_tick #(
  parameter int HALF_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lcdser_shifter.sv
module lcdser_shifter
  import lcdser_pkg::*;
#(
  parameter int HALF_CLKS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  input  logic               rx_mode,
  input  logic               sdi,
  output logic               cs_n,
  output logic               sclk,
  output logic               sdo,
  output logic               sdo_en,
  output logic               last_edge,
  output logic [BYTE_W-1:0]  rx_next
);
  localparam int IDX_W = $clog2(FRAME_W);

  logic               active;
  logic               tick;
  logic               rxm;
  logic [IDX_W-1:0]   bit_idx;
  logic [IDX_W-1:0]   nxt_idx;
  logic [FRAME_W-1:0] sh;
  logic [BYTE_W-1:0]  rx_sh;
  logic               in_data;
  logic               nxt_release;

  lcdser_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .tick (tick)
  );

  assign nxt_idx     = bit_idx + 1'b1;
  assign in_data     = (bit_idx >= IDX_W'(DATA_START));
  assign nxt_release = rxm && (nxt_idx >= IDX_W'(DATA_START));
  assign last_edge   = tick && sclk && (bit_idx == IDX_W'(FRAME_W - 1));
  assign rx_next     = {rx_sh[BYTE_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      sdo     <= 1'b0;
      sdo_en  <= 1'b1;
      bit_idx <= '0;
      sh      <= '0;
      rx_sh   <= '0;
      rxm     <= 1'b0;
    end else if (!active) begin
      if (start) begin
        active  <= 1'b1;
        cs_n    <= 1'b0;
        sclk    <= 1'b0;
        sh      <= word;
        sdo     <= word[FRAME_W-1];
        sdo_en  <= 1'b1;
        bit_idx <= '0;
        rxm     <= rx_mode;
        rx_sh   <= '0;
      end
    end else if (tick) begin
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (rxm && in_data) begin
          rx_sh <= rx_next;
        end
        if (bit_idx == IDX_W'(FRAME_W - 1)) begin
          active <= 1'b0;
          cs_n   <= 1'b1;
          sdo    <= 1'b0;
          sdo_en <= 1'b1;
        end else begin
          bit_idx <= nxt_idx;
          sh      <= {sh[FRAME_W-2:0], 1'b0};
          sdo_en  <= !nxt_release;
          sdo     <= nxt_release ? 1'b0 : sh[FRAME_W-2];
        end
      end
    end
  end

  AST_CS_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!sclk && !sdo)); // R1

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !cs_n); // R2

  AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo)); // R6

  AST_RELEASE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    !sdo_en |-> (!cs_n && rxm && !sdo)); // R10

endmodule

// File: rtl/lcdser_seq.sv
module lcdser_seq
  import lcdser_pkg::*;
#(
  parameter int GAP_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_read,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BYTE_W-1:0]  req_wdata,
  input  logic               last_edge,
  input  logic [BYTE_W-1:0]  rx_next,
  output logic               busy,
  output logic               start,
  output logic [FRAME_W-1:0] word,
  output logic               rx_mode,
  output logic               rd_valid,
  output logic [BYTE_W-1:0]  rd_data
);
  localparam int GW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
  localparam int FW = $clog2(NUM_FRAMES);

  seq_state_t        state;
  logic [FW-1:0]     frame_no;
  logic [GW-1:0]     gcnt;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              read_q;
  logic              last_frame;

  assign last_frame = (frame_no == FW'(NUM_FRAMES - 1));
  assign rx_mode    = read_q && last_frame;

  always_comb begin
    unique case (frame_no)
      FW'(0):  word = build_frame('{rnw: 1'b0, dcx: 1'b0, hsel: 1'b1}, addr_q[ADDR_W-1:BYTE_W]);
      FW'(1):  word = build_frame('{rnw: 1'b0, dcx: 1'b0, hsel: 1'b0}, addr_q[BYTE_W-1:0]);
      default: word = read_q ? build_frame('{rnw: 1'b1, dcx: 1'b1, hsel: 1'b0}, '0)
                             : build_frame('{rnw: 1'b0, dcx: 1'b1, hsel: 1'b0}, wdata_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      busy     <= 1'b0;
      start    <= 1'b0;
      frame_no <= '0;
      gcnt     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      read_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      start    <= 1'b0;
      rd_valid <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (req_valid) begin
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            read_q   <= req_read;
            frame_no <= '0;
            busy     <= 1'b1;
            start    <= 1'b1;
            state    <= SQ_FRAME;
          end
        end
        SQ_FRAME: begin
          if (last_edge) begin
            if (last_frame) begin
              busy  <= 1'b0;
              state <= SQ_IDLE;
              if (read_q) begin
                rd_valid <= 1'b1;
                rd_data  <= rx_next;
              end
            end else begin
              frame_no <= frame_no + 1'b1;
              gcnt     <= '0;
              state    <= SQ_GAP;
            end
          end
        end
        SQ_GAP: begin
          if (gcnt == GW'(GAP_CLKS - 1)) begin
            start <= 1'b1;
            state <= SQ_FRAME;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> ($stable(addr_q) && $stable(read_q) && $stable(wdata_q))); // R9

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R5

  AST_VALID_AT_END: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($fell(busy) && read_q)); // R5

  AST_BUSY_END_FRAME: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(last_edge)); // R8

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (rst)
    frame_no <= FW'(NUM_FRAMES - 1)); // R3

endmodule

// File: rtl/lcd_reg_port.sv
module lcd_reg_port
  import lcdser_pkg::*;
#(
  parameter int HALF_CLKS = 2,
  parameter int GAP_CLKS  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        busy,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        lcd_cs_n,
  output logic        lcd_sclk,
  output logic        lcd_sdo,
  output logic        lcd_sdo_en,
  input  logic        lcd_sdi
);
  logic               start;
  logic [FRAME_W-1:0] word;
  logic               rx_mode;
  logic               last_edge;
  logic [BYTE_W-1:0]  rx_next;

  lcdser_seq #(.GAP_CLKS(GAP_CLKS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_read  (req_read),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .last_edge (last_edge),
    .rx_next   (rx_next),
    .busy      (busy),
    .start     (start),
    .word      (word),
    .rx_mode   (rx_mode),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  lcdser_shifter #(.HALF_CLKS(HALF_CLKS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .word      (word),
    .rx_mode   (rx_mode),
    .sdi       (lcd_sdi),
    .cs_n      (lcd_cs_n),
    .sclk      (lcd_sclk),
    .sdo       (lcd_sdo),
    .sdo_en    (lcd_sdo_en),
    .last_edge (last_edge),
    .rx_next   (rx_next)
  );

  AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (rst)
    !lcd_cs_n |-> busy); // R8

endmodule

// File: tb/test_lcd_reg_port.sv
module test_lcd_reg_port;
  localparam int HALF = 3;
  localparam int GAP  = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_read = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, rd_valid, lcd_cs_n, lcd_sclk, lcd_sdo, lcd_sdo_en;
  logic [7:0]  rd_data;
  logic        lcd_sdi = 1'b0;

  always #4 clk = ~clk;

  lcd_reg_port #(.HALF_CLKS(HALF), .GAP_CLKS(GAP)) i_lcd_reg_port (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .lcd_cs_n(lcd_cs_n),
    .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo), .lcd_sdo_en(lcd_sdo_en),
    .lcd_sdi(lcd_sdi)
  );

  int chk = 0;
  int fails = 0;
  bit done = 0;

  // monitor / slave state
  logic [7:0]  sl_rdata = 8'h00;
  logic [15:0] frames [0:7];
  logic [15:0] oelog  [0:7];
  int          fbits  [0:7];
  int nfr, rcnt, hi_run, lo_run, cs_hi_run, min_gap;
  int bad_half, sdo_hi_bad, idle_bad, busy_bad, rdv_cnt, rdv_bad;
  logic [15:0] fword, oew;
  logic [7:0]  rdv_data;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;

  task automatic clear_mon();
    nfr = 0; rcnt = 0; hi_run = 0; lo_run = 0; min_gap = 1000;
    bad_half = 0; sdo_hi_bad = 0; idle_bad = 0; busy_bad = 0;
    rdv_cnt = 0; rdv_bad = 0; rdv_data = 8'h00; fword = '0; oew = '0;
    for (int i = 0; i < 8; i++) begin frames[i] = '0; oelog[i] = '0; fbits[i] = 0; end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (lcd_cs_n && lcd_sclk) idle_bad++;
      if (rd_valid) begin
        rdv_cnt++;
        rdv_data = rd_data;
        if (!(!p_cs && lcd_cs_n)) rdv_bad++;
      end
      if (p_cs && !lcd_cs_n) begin
        if ((nfr % 3) != 0 && cs_hi_run < min_gap) min_gap = cs_hi_run;
        rcnt = 0; fword = '0; oew = '0; lo_run = 1; hi_run = 0;
      end else if (!p_cs && lcd_cs_n) begin
        if (hi_run != HALF) bad_half++;
        if (nfr < 8) begin frames[nfr] = fword; oelog[nfr] = oew; fbits[nfr] = rcnt; end
        nfr++;
        if (busy != ((nfr % 3) != 0)) busy_bad++;
      end else if (!lcd_cs_n) begin
        if (!p_sclk && lcd_sclk) begin
          rcnt++;
          fword = {fword[14:0], lcd_sdo};
          oew   = {oew[14:0], lcd_sdo_en};
          if (lo_run != HALF) bad_half++;
          hi_run = 1;
        end else if (p_sclk && lcd_sclk) begin
          hi_run++;
          if (lcd_sdo != p_sdo) sdo_hi_bad++;
        end else if (p_sclk && !lcd_sclk) begin
          if (hi_run != HALF) bad_half++;
          lo_run = 1;
          if (rcnt >= 8 && rcnt < 16) lcd_sdi = sl_rdata[15-rcnt];
        end else begin
          lo_run++;
        end
      end
      if (lcd_cs_n) cs_hi_run = p_cs ? cs_hi_run + 1 : 1;
      p_cs = lcd_cs_n; p_sclk = lcd_sclk; p_sdo = lcd_sdo;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chk++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit rd, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    check(!busy, "R8 access completes", busy, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(lcd_cs_n == 1'b1, "R1 cs_n idle", lcd_cs_n, 1);
    check(lcd_sclk == 1'b0 && lcd_sdo == 1'b0, "R1 sclk/sdo idle", {lcd_sclk, lcd_sdo}, 0);
    check(busy == 1'b0 && rd_valid == 1'b0, "R1 busy/rd_valid idle", {busy, rd_valid}, 0);
  endtask

  task automatic check_timing(input string tag);
    check(bad_half == 0, {tag, " R6 half period"}, bad_half, 0);
    check(sdo_hi_bad == 0, {tag, " R6 sdo stable high"}, sdo_hi_bad, 0);
    check(idle_bad == 0, {tag, " R2 sclk only in frame"}, idle_bad, 0);
    check(min_gap >= GAP, {tag, " R7 gap"}, min_gap, GAP);
    check(busy_bad == 0, {tag, " R8 busy at frame ends"}, busy_bad, 0);
    for (int i = 0; i < 3; i++) check(fbits[i] == 16, {tag, " R2 bits per frame"}, fbits[i], 16);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [7:0] d);
    clear_mon();
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'b0; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    wait_idle();
    check(nfr == 3, "R3 frame count", nfr, 3);
    check(frames[0] == (16'h2000 | {8'h00, a[15:8]}), "R3 frame 1", frames[0], 16'h2000 | {8'h00, a[15:8]});
    check(frames[1] == {8'h00, a[7:0]}, "R3 frame 2", frames[1], {8'h00, a[7:0]});
    check(frames[2] == (16'h4000 | {8'h00, d}), "R3 frame 3", frames[2], 16'h4000 | {8'h00, d});
    check(oelog[2] == 16'hFFFF && oelog[0] == 16'hFFFF, "R10 sdo_en on write", oelog[2], 16'hFFFF);
    check(rdv_cnt == 0, "R5 no strobe on write", rdv_cnt, 0);
    check_timing("write");
  endtask

  task automatic t_read(input logic [15:0] a, input logic [7:0] slv);
    clear_mon();
    sl_rdata = slv;
    do_req(1'b1, a, 8'h00);
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    wait_idle();
    check(nfr == 3, "R4 frame count", nfr, 3);
    check(frames[0] == (16'h2000 | {8'h00, a[15:8]}), "R4 frame 1", frames[0], 16'h2000 | {8'h00, a[15:8]});
    check(frames[1] == {8'h00, a[7:0]}, "R4 frame 2", frames[1], {8'h00, a[7:0]});
    check(frames[2] == 16'hC000, "R4 read header", frames[2], 16'hC000);
    check(oelog[2] == 16'hFF00, "R4 R10 release window", oelog[2], 16'hFF00);
    check(rdv_cnt == 1, "R5 one strobe", rdv_cnt, 1);
    check(rdv_bad == 0, "R5 strobe at cs rise", rdv_bad, 0);
    check(rdv_data == slv, "R5 read byte", rdv_data, slv);
    check_timing("read");
  endtask

  task automatic t_ignore();
    clear_mon();
    do_req(1'b0, 16'hB602, 8'h30);
    repeat (40) @(negedge clk);
    do_req(1'b1, 16'h1234, 8'h77);
    wait_idle();
    repeat (200) @(negedge clk);
    check(nfr == 3, "R9 no extra frames", nfr, 3);
    check(frames[0] == 16'h20B6 && frames[1] == 16'h0002, "R9 address kept", frames[1], 16'h0002);
    check(frames[2] == 16'h4030, "R9 data kept", frames[2], 16'h4030);
    check(rdv_cnt == 0, "R9 ignored read gives no strobe", rdv_cnt, 0);
  endtask

  initial begin
    clear_mon();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write(16'hC001, 8'h86);
    t_write(16'h3600, 8'h41);
    t_read(16'hB602, 8'hA5);
    t_read(16'hE011, 8'h5A);
    t_read(16'hFFFF, 8'h81);
    t_ignore();
    t_write(16'h0000, 8'hFF);
    t_reset();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", chk - fails, chk);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", chk - fails, chk);
    end
    $finish;
  end

endmodule